// File: doc/BRIEF.md
# Quarter-Rate QPSK Passband Modulator

This block turns a serial bit stream into a digital QPSK passband waveform, one signed sample per clock. It pulls bits from upstream with a request strobe and groups them in pairs. The first bit of a pair selects the in-phase level and the second selects the quadrature level. Each level is a fixed amplitude whose sign the bit chooses. The sample is the in-phase level times a cosine carrier, minus the quadrature level times a sine carrier.

The carrier runs at exactly one quarter of the clock rate, so one carrier cycle spans four samples. The cosine and sine carriers therefore reduce to four-step sign patterns, and no multipliers or sine tables are needed. A symbol lasts a whole number of carrier cycles, two by default, which gives eight clocks per symbol. Each new symbol starts at carrier phase zero. A downstream DAC path or pulse shaper takes the sample together with its valid flag.

Top module: `qpsk_quarter_mod`

## Requirements
- R1: While synchronous reset is high, and in the first cycle after it falls, `sampleOut` is 0, `sampleValid` is 0 and `bitReq` is 0.
- R2: Cycles are counted modulo 8 from the first cycle after reset, starting at index 0. `bitReq` is high in exactly the cycles with index 6 and 7 and low in all other cycles.
- R3: The bit on `bitIn` in an index-6 request cycle sets the in-phase level, and the bit in the index-7 cycle sets the quadrature level. Bit 0 gives level +2040 and bit 1 gives level -2040 (Q1.11). `bitIn` is ignored in cycles without a request.
- R4: When valid, `sampleOut` = I·cos − Q·sin. The carrier phase is the cycle index mod 4. The cosine takes the values +1, 0, −1, 0 over phases 0 to 3, and the sine takes 0, +1, 0, −1. The sample is therefore I, −Q, −I, +Q over phases 0 to 3.
- R5: A bit pair requested at indices 6 and 7 takes effect at the next index-0 cycle, which is carrier phase zero. It is then held for all eight cycles of that symbol.
- R6: `sampleValid` goes high at the index-0 cycle after the first complete bit pair. It then stays high on every clock until reset.
- R7: `sampleOut` never leaves the range −2040 to +2040.
- R8: A reset asserted in the middle of a stream returns the block to the R1 state. Timing then restarts at index 0 and the old symbol is discarded.
- R9: While `sampleValid` is low, `sampleOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| bitIn | input | 1 | Serial data bit, sampled at a clock edge where `bitReq` is high |
| bitReq | output | 1 | Bit request strobe, two cycles per symbol |
| sampleOut | output | 12 | Signed Q1.11 passband sample |
| sampleValid | output | 1 | High once the first symbol is loaded |

## Verification
The bound checker checks several properties on every clock. It confirms that requests come in pairs, that valid stays high once raised, that the output is zero while invalid and stays within the amplitude bound, and that a new symbol lands on phase zero. It also checks that, away from a symbol load, each sample is the negation of the sample two clocks earlier, which is the half-cycle symmetry of a quarter-rate carrier. Only the directed scenarios can show which bit maps to which axis and which sign a bit produces. They also show that the request timing counts from reset release and that bits offered outside a request are discarded.

// File: rtl/qpsk_quarter_mod_pkg.sv
package qpsk_quarter_mod_pkg;

  // Strobes passed from the control to the datapath.
  typedef struct packed {
    logic       takeI;     // latch in-phase bit this edge
    logic       takeQ;     // latch quadrature bit and commit the symbol
    logic [1:0] phase;     // carrier phase index, 0..3
    logic       symValid;  // a full symbol has been committed
  } qmodStrobes_t;

endpackage

// File: rtl/qmod_ctrl.sv
module qmod_ctrl
  import qpsk_quarter_mod_pkg::*;
#(
  parameter int CARRIERS_PER_SYM = 2
) (
  input  logic         clk,
  input  logic         rst,
  output qmodStrobes_t strb,
  output logic         bitReq
);

  localparam int SYM_CLKS = 4 * CARRIERS_PER_SYM;
  localparam int CNT_W    = $clog2(SYM_CLKS);
  localparam logic [CNT_W-1:0] LAST_IDX  = CNT_W'(SYM_CLKS - 1);
  localparam logic [CNT_W-1:0] FIRST_REQ = CNT_W'(SYM_CLKS - 2);

  logic [CNT_W-1:0] symCnt;
  logic             validReg;
  logic             reqI;
  logic             reqQ;

  assign reqI = (symCnt == FIRST_REQ);
  assign reqQ = (symCnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      symCnt   <= '0;
      validReg <= 1'b0;
    end else begin
      symCnt <= reqQ ? '0 : symCnt + 1'b1;
      if (reqQ) validReg <= 1'b1;
    end
  end

  always_comb begin
    strb.takeI    = reqI;
    strb.takeQ    = reqQ;
    strb.phase    = symCnt[1:0];
    strb.symValid = validReg;
  end

  assign bitReq = reqI | reqQ;

endmodule

// File: rtl/qmod_datapath.sv
module qmod_datapath
  import qpsk_quarter_mod_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int AMPLITUDE = 2040
) (
  input  logic                       clk,
  input  logic                       rst,
  input  qmodStrobes_t               strb,
  input  logic                       bitIn,
  output logic signed [SAMPLE_W-1:0] sampleOut
);

  localparam logic signed [SAMPLE_W-1:0] POS_LVL = SAMPLE_W'(AMPLITUDE);
  localparam logic signed [SAMPLE_W-1:0] NEG_LVL = -POS_LVL;

  logic                       iHeld;
  logic                       symI;
  logic                       symQ;
  logic signed [SAMPLE_W-1:0] lvlI;
  logic signed [SAMPLE_W-1:0] lvlQ;
  logic signed [SAMPLE_W-1:0] mixed;

  always_ff @(posedge clk) begin
    if (rst) begin
      iHeld <= 1'b0;
      symI  <= 1'b0;
      symQ  <= 1'b0;
    end else begin
      if (strb.takeI) iHeld <= bitIn;
      if (strb.takeQ) begin
        symI <= iHeld;
        symQ <= bitIn;
      end
    end
  end

  // Bit 0 -> +A, bit 1 -> -A
  assign lvlI = symI ? NEG_LVL : POS_LVL;
  assign lvlQ = symQ ? NEG_LVL : POS_LVL;

  // I*cos - Q*sin with cos = +1,0,-1,0 and sin = 0,+1,0,-1
  always_comb begin
    unique case (strb.phase)
      2'd0:    mixed = lvlI;
      2'd1:    mixed = -lvlQ;
      2'd2:    mixed = -lvlI;
      default: mixed = lvlQ;
    endcase
  end

  assign sampleOut = strb.symValid ? mixed : '0;

endmodule

// File: rtl/qpsk_quarter_mod.sv
module qpsk_quarter_mod
  import qpsk_quarter_mod_pkg::*;
#(
  parameter int SAMPLE_W         = 12,
  parameter int AMPLITUDE        = 2040,
  parameter int CARRIERS_PER_SYM = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bitIn,
  output logic                       bitReq,
  output logic signed [SAMPLE_W-1:0] sampleOut,
  output logic                       sampleValid
);

  qmodStrobes_t strb;

  qmod_ctrl #(
    .CARRIERS_PER_SYM(CARRIERS_PER_SYM)
  ) ctrl_i (
    .clk   (clk),
    .rst   (rst),
    .strb  (strb),
    .bitReq(bitReq)
  );

  qmod_datapath #(
    .SAMPLE_W (SAMPLE_W),
    .AMPLITUDE(AMPLITUDE)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .bitIn    (bitIn),
    .sampleOut(sampleOut)
  );

  assign sampleValid = strb.symValid;

endmodule

// File: rtl/qpsk_quarter_mod_chk.sv
module qpsk_quarter_mod_chk
  import qpsk_quarter_mod_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int AMPLITUDE = 2040
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       bitReq,
  input logic                       sampleValid,
  input logic signed [SAMPLE_W-1:0] sampleOut,
  input qmodStrobes_t               strb
);

  localparam logic signed [SAMPLE_W-1:0] POS_LVL = SAMPLE_W'(AMPLITUDE);
  localparam logic signed [SAMPLE_W-1:0] NEG_LVL = -POS_LVL;

  // R2: a request that starts is followed by exactly one more
  a_r2_req_pair_start: assert property (@(posedge clk) disable iff (rst)
    (bitReq && !$past(bitReq)) |=> bitReq);
  a_r2_req_pair_end: assert property (@(posedge clk) disable iff (rst)
    (bitReq && $past(bitReq)) |=> !bitReq);

  // R6: valid stays high once raised
  a_r6_valid_sticky: assert property (@(posedge clk) disable iff (rst)
    sampleValid |=> sampleValid);

  // R9: zero output while invalid
  a_r9_zero_invalid: assert property (@(posedge clk) disable iff (rst)
    !sampleValid |-> (sampleOut == '0));

  // R7: amplitude bound
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (sampleOut <= POS_LVL) && (sampleOut >= NEG_LVL));

  // R5: a committed symbol lands on carrier phase zero
  a_r5_load_phase0: assert property (@(posedge clk) disable iff (rst)
    $past(strb.takeQ) |-> (strb.phase == 2'd0));

  // R4: half-cycle symmetry of the quarter-rate carrier inside a symbol
  a_r4_half_cycle: assert property (@(posedge clk) disable iff (rst)
    (sampleValid && $past(sampleValid, 2) && !$past(strb.takeQ) && !$past(strb.takeQ, 2))
      |-> (sampleOut == -$past(sampleOut, 2)));

endmodule

bind qpsk_quarter_mod qpsk_quarter_mod_chk #(
  .SAMPLE_W (SAMPLE_W),
  .AMPLITUDE(AMPLITUDE)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .bitReq     (bitReq),
  .sampleValid(sampleValid),
  .sampleOut  (sampleOut),
  .strb       (strb)
);

// File: tb/qpsk_quarter_mod_tb.sv
module qpsk_quarter_mod_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AMP        = 2040;
  localparam int SYM_CLKS   = 8;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               bitIn = 1'b0;
  logic               bitReq;
  logic signed [11:0] sampleOut;
  logic               sampleValid;

  int nChecks = 0;
  int nFails  = 0;
  bit summaryDone = 0;

  // Bench model state
  int mCnt = 0;
  bit mValid = 0;
  bit mI = 0;
  bit mQ = 0;
  bit pendI = 0;
  bit srcBits[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  qpsk_quarter_mod dut_i (
    .clk        (clk),
    .rst        (rst),
    .bitIn      (bitIn),
    .bitReq     (bitReq),
    .sampleOut  (sampleOut),
    .sampleValid(sampleValid)
  );

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (cycle index %0d)", req, act, exp, mCnt);
    end
  endtask

  function automatic int expSample();
    int li = mI ? -AMP : AMP;
    int lq = mQ ? -AMP : AMP;
    if (!mValid) return 0;
    case (mCnt % 4)
      0: return li;
      1: return -lq;
      2: return -li;
      default: return lq;
    endcase
  endfunction

  // Called at a negedge: check outputs, drive input, advance one clock.
  task automatic stepCycle();
    int s = int'(sampleOut);
    int mag = (s < 0) ? -s : s;
    bit b;
    string tag;
    check("R6", int'(sampleValid), int'(mValid));
    if (!mValid) tag = "R9";
    else if (mCnt == 0) tag = "R5";
    else if (mCnt % 4 < 2) tag = "R3";
    else tag = "R4";
    check(tag, s, expSample());
    check("R2", int'(bitReq), int'(mCnt == SYM_CLKS-2 || mCnt == SYM_CLKS-1));
    check("R7", int'(mag <= AMP), 1);
    if (mCnt == SYM_CLKS-2 || mCnt == SYM_CLKS-1) begin
      b = (srcBits.size() > 0) ? srcBits.pop_front() : 1'b0;
      bitIn = b;
      if (mCnt == SYM_CLKS-2) pendI = b;
      else begin
        mI = pendI; mQ = b; mValid = 1;
      end
    end else begin
      bitIn = ~bitIn; // R3: junk outside requests must be ignored
    end
    mCnt = (mCnt + 1) % SYM_CLKS;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset(string req);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req, int'(sampleOut), 0);
    check(req, int'(sampleValid), 0);
    check(req, int'(bitReq), 0);
    rst = 1'b0;
    mCnt = 0; mValid = 0; mI = 0; mQ = 0; pendI = 0;
    srcBits.delete();
    @(posedge clk);
    @(negedge clk);
    // first cycle after reset release is index 0 once the edge has passed
    mCnt = 1;
  endtask

  task automatic runCycles(int n);
    for (int k = 0; k < n; k++) stepCycle();
  endtask

  task automatic testResetState();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1", int'(sampleOut), 0);
    check("R1", int'(sampleValid), 0);
    check("R1", int'(bitReq), 0);
    rst = 1'b0;
    mCnt = 0; mValid = 0;
    srcBits.delete();
    runCycles(SYM_CLKS); // R1 index 0 state, then first symbol
  endtask

  task automatic testAllPairs();
    doReset("R1");
    srcBits = '{0,0, 0,1, 1,0, 1,1, 1,1, 0,0};
    runCycles(SYM_CLKS * 7 - 1);
  endtask

  task automatic testAlternating();
    doReset("R1");
    for (int k = 0; k < 16; k++) srcBits.push_back(k[0]);
    runCycles(SYM_CLKS * 9 - 1);
  endtask

  task automatic testPseudo();
    logic [6:0] lfsr = 7'h5A;
    doReset("R1");
    for (int k = 0; k < 80; k++) begin
      srcBits.push_back(lfsr[0]);
      lfsr = {lfsr[5:0], lfsr[6] ^ lfsr[5]};
    end
    runCycles(SYM_CLKS * 41 - 1);
  endtask

  task automatic testMidReset();
    doReset("R1");
    srcBits = '{1,1, 0,1, 1,0};
    runCycles(SYM_CLKS * 3 + 2);
    doReset("R8");
    srcBits = '{0,1};
    runCycles(SYM_CLKS * 2 - 1); // R8: valid again only after new pair
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!summaryDone) begin
      summaryDone = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    end
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    testResetState();
    testAllPairs();
    testAlternating();
    testPseudo();
    testMidReset();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    end
    $finish;
  end

endmodule